// File: doc/BRIEF.md
# Sequential Stream Buffer Prefetcher

This block sits between a cache and the memory behind it. The cache sends block-address misses to it and receives filled blocks back from it. When a miss matches nothing the block holds, the block issues a demand request to memory for the missed block. It also restarts one of its stream buffers at the next consecutive block address. That stream then keeps fetching ahead in sequence until its FIFO is full. Prefetched blocks stay in the stream FIFOs, not in the cache, until a later miss asks for one of them.

Several streams run side by side, so interleaved sequential walks through instruction or data memory are each followed separately. Only the oldest entry of each stream, its head, is compared with an incoming miss. A head hit hands the block to the cache, advances that FIFO and frees a slot, which prefetches the next block in line. If the head's data has not yet come back from memory, the hit waits for it. When no head matches, the least recently used stream is discarded and reused. Demand requests always take the memory port ahead of prefetches. Memory responses carry their block address, so they may return in any latency, and a response that matches no waiting entry is dropped.

The controller handles one miss at a time and has five states:
- IDLE accepts a miss and moves to LOOKUP.
- LOOKUP compares the heads. It goes back to IDLE on a hit whose data is present, to HEAD_WAIT on a hit whose data is outstanding, and to DEMAND_REQ on no match.
- HEAD_WAIT returns to IDLE when the head's data arrives.
- DEMAND_REQ moves to DEMAND_WAIT when memory accepts the request.
- DEMAND_WAIT returns to IDLE when the response for the missed address arrives.

Top module: `stream_prefetcher`

## Requirements
- R1: While reset is asserted and right after it is released, `miss_ready` is 1, `fill_valid` is 0 and `mem_req_valid` is 0.
- R2: Every accepted miss produces exactly one single-cycle `fill_valid` pulse, with `fill_addr` equal to the miss address and `fill_data` equal to the memory word for that address. `miss_ready` stays low from acceptance until that fill.
- R3: A miss that matches no stream head sends a memory request for the missed address itself. The replaced stream then requests addr+1, addr+2 and onward up to addr+DEPTH, in that order. With a memory that never stalls and no other stream active, exactly DEPTH+1 requests follow the miss.
- R4: A miss that hits a head whose data is present gets its fill in the cycle after the miss is accepted, with no memory request for that address. The freed slot then leads to a prefetch of the address DEPTH blocks past the consumed one.
- R5: Only head entries are compared. A miss to a block held deeper in a stream's FIFO is treated as a miss and sends a demand request.
- R6: A miss that hits a head whose prefetch is still outstanding produces no fill until memory returns that block, and it sends no demand request.
- R7: On a miss that matches no head, the least recently used stream is replaced. Both a head hit and a new allocation count as a use. After reset, streams are taken in index order starting at stream 0.
- R8: A pending demand request takes the memory port ahead of any waiting prefetch, so it is the first request accepted once memory becomes ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache presents a missed block address |
| miss_ready | output | 1 | Block can accept a miss (controller idle) |
| miss_addr | input | ADDR_W | Missed block address |
| fill_valid | output | 1 | One-cycle pulse returning the missed block to the cache |
| fill_addr | output | ADDR_W | Block address of the fill |
| fill_data | output | DATA_W | Block contents of the fill |
| mem_req_valid | output | 1 | Memory read request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_addr | output | ADDR_W | Block address requested from memory |
| mem_rsp_valid | input | 1 | Memory returns a block |
| mem_rsp_addr | input | ADDR_W | Block address of the returned data |
| mem_rsp_data | input | DATA_W | Returned block contents |

## Verification
Some properties are checked by assertions on every cycle. Fills are single-cycle pulses and only one miss is in flight at a time. A stream is popped only when its head is valid and ready, and its occupancy never exceeds its depth. A ready head stays ready until it is used. No prefetch is granted while a demand request is pending, and the recency ranking always has exactly one oldest stream. Other behaviours can only be shown by the bench's scenarios. These are the request order after a cold miss, the one-cycle latency of a ready head hit and the follow-on prefetch, the fact that deeper FIFO entries are not compared, the eviction order under a mix of hits and allocations, the held fill on an outstanding head, and the data returned to the cache across random stalls and latencies.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_HEAD_WAIT,
        ST_DEMAND_REQ,
        ST_DEMAND_WAIT
    } sbp_state_e;
endpackage

// File: rtl/sbp_lru.sv
module sbp_lru #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim
);
    logic [IW-1:0] rank [N];
    logic [N-1:0]  oldest;

    // rank N-1 = most recently used, rank 0 = replacement victim
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    rank[i] <= IW'(N - 1);
                else if (rank[i] > rank[touch_idx])
                    rank[i] <= rank[i] - 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < N; i++) begin
            oldest[i] = (rank[i] == '0);
            if (oldest[i]) victim = IW'(i);
        end
    end

    AST_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1); // R7
endmodule

// File: rtl/sbp_stream.sv
module sbp_stream #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = PW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              pop,
    input  logic              issue,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              head_ok,
    output logic [ADDR_W-1:0] head_addr,
    output logic              head_rdy,
    output logic [DATA_W-1:0] head_data,
    output logic              want,
    output logic [ADDR_W-1:0] want_addr
);
    logic              live;
    logic [ADDR_W-1:0] base;
    logic [PW-1:0]     hptr;
    logic [CW-1:0]     cnt;
    logic [DEPTH-1:0]  rdy;
    logic [DATA_W-1:0] dat [DEPTH];

    logic [ADDR_W-1:0] off;
    logic [PW-1:0]     slot;
    logic              wr_en;

    assign head_ok   = live && (cnt != '0);
    assign head_addr = base;
    assign head_rdy  = rdy[hptr];
    assign head_data = dat[hptr];
    assign want      = live && (cnt < CW'(DEPTH));
    assign want_addr = base + ADDR_W'(cnt);

    // entries hold base, base+1, ... so a response finds its slot by offset
    assign off   = rsp_addr - base;
    assign slot  = hptr + off[PW-1:0];
    assign wr_en = rsp_valid && live && !alloc &&
                   (off < ADDR_W'(cnt)) && !rdy[slot];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= 1'b0;
            base <= '0;
            hptr <= '0;
            cnt  <= '0;
            rdy  <= '0;
        end else if (alloc) begin
            live <= 1'b1;
            base <= alloc_addr;
            cnt  <= '0;
            rdy  <= '0;
        end else begin
            if (wr_en) rdy[slot] <= 1'b1;
            if (pop) begin
                rdy[hptr] <= 1'b0;
                hptr      <= hptr + 1'b1;
                base      <= base + 1'b1;
            end
            cnt <= cnt + CW'(issue) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) dat[slot] <= rsp_data;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R3
    AST_POP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_ok && head_rdy); // R4
    AST_ISSUE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> want && !alloc); // R3
    AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        head_ok && head_rdy && !pop && !alloc |=> head_rdy); // R6
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
    import sbp_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int STREAMS = 4,
    parameter int DEPTH   = 4,
    localparam int SW = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [DATA_W-1:0] fill_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    sbp_state_e state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [SW-1:0]     hit_q;

    logic              h_ok   [STREAMS];
    logic [ADDR_W-1:0] h_addr [STREAMS];
    logic              h_rdy  [STREAMS];
    logic [DATA_W-1:0] h_data [STREAMS];
    logic              w_on   [STREAMS];
    logic [ADDR_W-1:0] w_addr [STREAMS];
    logic [STREAMS-1:0] alloc, pop, issue;

    logic          any_hit, pf_any, pf_ok, demand, touch;
    logic [SW-1:0] hit_idx, pf_sel, victim, touch_idx;

    for (genvar g = 0; g < STREAMS; g++) begin : g_stream
        sbp_stream #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_stream (
            .clk(clk), .rst_n(rst_n),
            .alloc(alloc[g]), .alloc_addr(cur_addr + 1'b1),
            .pop(pop[g]), .issue(issue[g]),
            .rsp_valid(mem_rsp_valid), .rsp_addr(mem_rsp_addr), .rsp_data(mem_rsp_data),
            .head_ok(h_ok[g]), .head_addr(h_addr[g]), .head_rdy(h_rdy[g]),
            .head_data(h_data[g]), .want(w_on[g]), .want_addr(w_addr[g])
        );
    end

    sbp_lru #(.N(STREAMS)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(touch_idx), .victim(victim)
    );

    // head comparison and prefetch pick, lowest index first
    always_comb begin
        any_hit = 1'b0;
        hit_idx = '0;
        pf_any  = 1'b0;
        pf_sel  = '0;
        for (int i = STREAMS - 1; i >= 0; i--) begin
            if (h_ok[i] && h_addr[i] == cur_addr) begin
                any_hit = 1'b1;
                hit_idx = SW'(i);
            end
            if (w_on[i]) begin
                pf_any = 1'b1;
                pf_sel = SW'(i);
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            hit_q    <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && miss_valid) cur_addr <= miss_addr;
            if (state == ST_LOOKUP) hit_q <= hit_idx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:        if (miss_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP:      if (!any_hit) state_nx = ST_DEMAND_REQ;
                            else if (h_rdy[hit_idx]) state_nx = ST_IDLE;
                            else state_nx = ST_HEAD_WAIT;
            ST_HEAD_WAIT:   if (h_rdy[hit_q]) state_nx = ST_IDLE;
            ST_DEMAND_REQ:  if (mem_req_ready) state_nx = ST_DEMAND_WAIT;
            ST_DEMAND_WAIT: if (mem_rsp_valid && mem_rsp_addr == cur_addr) state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        miss_ready = (state == ST_IDLE);
        fill_addr  = cur_addr;
        fill_valid = 1'b0;
        fill_data  = mem_rsp_data;
        alloc      = '0;
        pop        = '0;
        issue      = '0;
        touch      = (state == ST_LOOKUP);
        touch_idx  = any_hit ? hit_idx : victim;
        demand     = (state == ST_DEMAND_REQ);
        pf_ok      = pf_any && !demand && (state != ST_LOOKUP);
        unique case (state)
            ST_LOOKUP: begin
                if (!any_hit) alloc[victim] = 1'b1;
                else if (h_rdy[hit_idx]) begin
                    fill_valid   = 1'b1;
                    fill_data    = h_data[hit_idx];
                    pop[hit_idx] = 1'b1;
                end
            end
            ST_HEAD_WAIT: begin
                if (h_rdy[hit_q]) begin
                    fill_valid = 1'b1;
                    fill_data  = h_data[hit_q];
                    pop[hit_q] = 1'b1;
                end
            end
            ST_DEMAND_WAIT: fill_valid = mem_rsp_valid && (mem_rsp_addr == cur_addr);
            default: ;
        endcase
        mem_req_valid = demand || pf_ok;
        mem_req_addr  = demand ? cur_addr : w_addr[pf_sel];
        if (pf_ok && mem_req_ready) issue[pf_sel] = 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_QUIET: assert (!fill_valid && !mem_req_valid); // R1
    end
    AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> !fill_valid); // R2
    AST_ONE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> !miss_ready); // R2
    AST_DEMAND_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEMAND_REQ) |-> (issue == '0)); // R8
endmodule

// File: tb/stream_prefetcher_bench.sv
`timescale 1ns/1ps
module stream_prefetcher_bench;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0, miss_ready;
    logic [AW-1:0] miss_addr = '0;
    logic fill_valid;
    logic [AW-1:0] fill_addr;
    logic [DW-1:0] fill_data;
    logic mem_req_valid, mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [AW-1:0] mem_rsp_addr = '0;
    logic [DW-1:0] mem_rsp_data = '0;

    stream_prefetcher u_stream_prefetcher (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr), .mem_rsp_data(mem_rsp_data)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // memory model state
    logic [AW-1:0] q_a [256];
    int q_due [256];
    int q_h = 0, q_t = 0;
    bit hold_req = 0, hold_rsp = 0, rnd = 0;
    logic [AW-1:0] rlog [256];
    int rn = 0;
    // monitor state
    logic [AW-1:0] cur = '0;
    bit busy = 0, saw_dem = 0;
    int fill_cnt = 0, fill_cyc = 0, hs_cyc = 0;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, ~a} + 32'h0101_0101;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit in_log(input logic [AW-1:0] a);
        for (int k = 0; k < rn && k < 256; k++) if (rlog[k] == a) return 1;
        return 0;
    endfunction

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (!hold_rsp && q_h != q_t && q_due[q_h % 256] <= cyc) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_addr  = q_a[q_h % 256];
            mem_rsp_data  = mem_word(q_a[q_h % 256]);
            q_h++;
        end
        mem_req_ready = hold_req ? 1'b0 : (rnd ? ($urandom % 4 != 0) : 1'b1);
        #1;
        if (rst_n) begin
            if (mem_req_valid && mem_req_ready) begin
                q_a[q_t % 256]   = mem_req_addr;
                q_due[q_t % 256] = cyc + (rnd ? 1 + int'($urandom % 6) : 2);
                q_t++;
                if (rn < 256) rlog[rn] = mem_req_addr;
                rn++;
                if (busy && mem_req_addr == cur) saw_dem = 1;
            end
            if (fill_valid) begin
                chk(busy && fill_addr == cur, "R2 fill address", DW'(fill_addr), DW'(cur));
                chk(fill_data == mem_word(cur), "R2 fill data", fill_data, mem_word(cur));
                fill_cnt++;
                fill_cyc = cyc;
                busy = 0;
            end
        end
    end

    task automatic miss_start(input logic [AW-1:0] a);
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        cur        = a;
        saw_dem    = 0;
        #1;
        while (!miss_ready) begin @(negedge clk); #1; end
        hs_cyc = cyc;
        busy   = 1;
        @(negedge clk);
        miss_valid = 1'b0;
    endtask

    task automatic miss_wait();
        int w = 0;
        while (busy && w < 3000) begin @(negedge clk); w++; end
        if (busy) chk(0, "R2 miss never filled", 0, 1);
        busy = 0;
    endtask

    task automatic do_miss(input logic [AW-1:0] a);
        miss_start(a);
        miss_wait();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL R2 watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [AW-1:0] base [6];
        logic [AW-1:0] off [6];
        void'($urandom(32'd4242));
        idle(3);
        #1;
        chk(miss_ready && !fill_valid && !mem_req_valid, "R1 in reset",
            {29'd0, miss_ready, fill_valid, mem_req_valid}, 32'h4);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(miss_ready && !fill_valid && !mem_req_valid, "R1 after reset",
            {29'd0, miss_ready, fill_valid, mem_req_valid}, 32'h4);

        // R3: cold miss, demand then DEPTH sequential prefetches
        rn = 0;
        do_miss(16'h0100);
        idle(20);
        chk(rn == 5, "R3 request count", rn, 5);
        chk(rlog[0] == 16'h0100, "R3 demand first", DW'(rlog[0]), 32'h100);
        for (int k = 1; k <= 4; k++)
            chk(rlog[k] == 16'h0100 + AW'(k), "R3 prefetch order", DW'(rlog[k]), 32'h100 + k);
        do_miss(16'h0200); idle(20);
        do_miss(16'h0300); idle(20);
        do_miss(16'h0400); idle(20);

        // R4: ready head hit
        rn = 0;
        do_miss(16'h0101);
        chk(fill_cyc == hs_cyc + 1, "R4 hit latency", fill_cyc - hs_cyc, 1);
        chk(!saw_dem, "R4 no demand on hit", saw_dem, 0);
        idle(10);
        chk(in_log(16'h0105), "R4 refill prefetch", in_log(16'h0105), 1);

        // R7: LRU replacement (streams 0x200 then 0x300 evicted)
        do_miss(16'h0500); idle(20);
        do_miss(16'h0201);
        chk(saw_dem, "R7 evicted stream misses", saw_dem, 1);
        idle(20);
        do_miss(16'h0102);
        chk(!saw_dem && fill_cyc == hs_cyc + 1, "R7 recent stream kept", fill_cyc - hs_cyc, 1);
        do_miss(16'h0301);
        chk(saw_dem, "R7 second eviction", saw_dem, 1);
        idle(20);

        // R5: block deeper in a stream is not a hit
        do_miss(16'h0503);
        chk(saw_dem, "R5 non-head demand", saw_dem, 1);
        idle(20);

        // R8: demand beats a waiting prefetch
        hold_req = 1;
        do_miss(16'h0103);
        miss_start(16'h0900);
        idle(3);
        rn = 0;
        hold_req = 0;
        miss_wait();
        chk(rn > 0 && rlog[0] == 16'h0900, "R8 demand first", DW'(rlog[0]), 32'h900);
        idle(20);

        // R6: head hit on outstanding prefetch waits
        hold_rsp = 1;
        do_miss(16'h0104);
        do_miss(16'h0105);
        do_miss(16'h0106);
        do_miss(16'h0107);
        miss_start(16'h0108);
        idle(10);
        chk(busy, "R6 no early fill", busy, 1);
        chk(!saw_dem, "R6 no demand", saw_dem, 0);
        hold_rsp = 0;
        miss_wait();
        chk(fill_cyc > hs_cyc + 10, "R6 waited for data", fill_cyc - hs_cyc, 11);
        idle(20);

        // random interleaved streams, R2 data checked per fill
        rnd = 1;
        for (int s = 0; s < 6; s++) begin
            base[s] = AW'($urandom);
            off[s]  = '0;
        end
        for (int n = 0; n < 400; n++) begin
            int s;
            s = int'($urandom % 6);
            if ($urandom % 10 == 0) off[s] = AW'($urandom % 32);
            do_miss(base[s] + off[s]);
            off[s] = off[s] + 1'b1;
            if ($urandom % 4 == 0) idle(int'($urandom % 8));
        end
        idle(30);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule